// File: doc/BRIEF.md
# External Bus Cycle Termination Controller

This block runs one external bus access at a time for a processor-side master. A request carries a halfword address, a direction, write data and a flag that marks the access as going to SDRAM. When the controller is idle it accepts the request. It then drives the address, the read/write line and an active-low chip select, and holds them steady until the access ends. The data path is 16 bits wide. Address bit 0 is therefore absent, and the address output carries bits 24 down to 1.

An access ends in one of two ways. The first is a programmed count of internal wait states. The second is an active-low acknowledge from the addressed device. That acknowledge is asynchronous to the bus clock, so it passes through a two-flop synchronizer and a falling-edge detector before it may end a cycle. This adds two clocks of latency. An acknowledge that is still held low from an earlier access is never taken as a new one. When acknowledge termination is enabled, the wait count remains as a timeout: if no edge arrives in time, the access ends internally and a timeout flag is raised. SDRAM accesses always end on the count.

The acknowledge enable and the wait count form a small configuration. It is loaded through a strobe and comes up from reset with acknowledge termination disabled and 15 wait states.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, busCsN is 1, done and timeout are 0, busDataOe is 0 and reqReady is 1. Acknowledge termination is disabled and the wait count is 15, so the first access ends 16 clocks after it is accepted, whatever busTaN does.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1, and busCsN goes low after that edge. Under internal termination with wait count W, done is 1 after the (W+1)-th rising edge following acceptance.
- R3: When acknowledge termination is enabled and the access is not SDRAM, busTaN may first be sampled low on rising edge n after being sampled high on an earlier edge. Done is then 1 after edge n+2, provided that edge comes no later than the timeout edge. If both fall on the same edge, the acknowledge wins and timeout stays 0.
- R4: A busTaN level that is already low when an access starts never ends that access. Only a return to high followed by a new low counts.
- R5: With acknowledge termination disabled, busTaN has no effect on when an access ends.
- R6: An access accepted with reqSdram = 1 ends after W+1 clocks even when a qualified acknowledge edge arrives, and its timeout is 0.
- R7: With acknowledge termination enabled on a non-SDRAM access and no qualified edge, the access ends after W+1 clocks with timeout = 1 in the same clock as done. In every other case timeout is 0.
- R8: For a read, rdData holds the busDataIn value sampled on the terminating rising edge. It is valid from the clock in which done is 1 until the next access ends.
- R9: While busCsN is low, busAddr, busRw and busDataOut stay constant. busRw is 1 for a read and 0 for a write. busDataOe is 1 only for a write while busCsN is low, and busDataOut then equals the request's write data.
- R10: done is 1 for exactly one clock per access, and busCsN is already 1 in that clock. busCsN stays high for at least two clocks between accesses, and reqReady is 1 in the clock after done.
- R11: A rising edge with cfgLoad = 1 stores cfgAckEn and cfgWait. The stored values govern every access accepted on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset, synchronous release |
| cfgLoad | input | 1 | Store cfgAckEn and cfgWait on this edge |
| cfgAckEn | input | 1 | Enable external acknowledge termination |
| cfgWait | input | WAIT_W | Wait-state count (timeout when acknowledge is enabled) |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request will be taken |
| reqAddr | input | ADDR_W | Halfword address, bits ADDR_W..1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| reqSdram | input | 1 | Access targets SDRAM, internal termination only |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Access ended by count while acknowledge was expected |
| busAddr | output | ADDR_W | External address bits ADDR_W..1 |
| busRw | output | 1 | 1 = read, 0 = write |
| busCsN | output | 1 | Active-low chip select |
| busDataOut | output | DATA_W | Write data to the bus |
| busDataOe | output | 1 | Drive enable for busDataOut |
| busDataIn | input | DATA_W | Read data from the bus |
| busTaN | input | 1 | Asynchronous active-low transfer acknowledge |

## Verification
Bus signals change one clock after acceptance. Done, timeout and read data appear after the (W+1)-th clock under the count. After an acknowledge they appear two edges after the edge that first samples busTaN low. The bench drives every input on the falling clock edge and samples every output on the falling edge after each rising edge. It numbers rising edges from acceptance and computes the expected edge of completion with a function of W, the enable, the SDRAM flag and the edge at which it lowered busTaN. Done is checked to be low before that edge, high on it and low one edge later. The held-over acknowledge case, the tie with the timeout and W = 0 are run as directed accesses among the random ones.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RECOVER = 2'd2
  } btcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture request, open chip select
    logic capRead;    // terminating edge: sample read data, close chip select
  } btcStrobe_t;

endpackage

// File: rtl/btc_ack_sync.sv
module btc_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic taNAsync,
  output logic taFall
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  // resynchronizer chain, reset to the negated level
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= taNAsync;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[LAST];
  end

  // new assertion: seen high last clock, low now
  assign taFall = prevQ & ~syncQ[LAST];

endmodule

// File: rtl/btc_datapath.sv
module btc_datapath
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  btcStrobe_t        strobe,
  input  logic [ADDR_W:1]   reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busTaN,
  output logic [ADDR_W:1]   busAddr,
  output logic              busRw,
  output logic              busCsN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              taFall
);

  logic [ADDR_W:1]   addrQ;
  logic              rwQ;
  logic              csNQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  btc_ack_sync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk      (clk),
    .rstN     (rstN),
    .taNAsync (busTaN),
    .taFall   (taFall)
  );

  // request capture, held for the whole access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      rwQ    <= 1'b1;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr;
      rwQ    <= ~reqWrite;
      wdataQ <= reqWdata;
    end
  end

  // chip select opens on capture, closes on the terminating edge
  always_ff @(posedge clk) begin
    if (!rstN)                csNQ <= 1'b1;
    else if (strobe.latchReq) csNQ <= 1'b0;
    else if (strobe.capRead)  csNQ <= 1'b1;
  end

  // read data sampled on the terminating rising edge
  always_ff @(posedge clk) begin
    if (!rstN)               rdataQ <= '0;
    else if (strobe.capRead) rdataQ <= busDataIn;
  end

  assign busAddr    = addrQ;
  assign busRw      = rwQ;
  assign busCsN     = csNQ;
  assign busDataOut = wdataQ;
  assign busDataOe  = ~csNQ & ~rwQ;
  assign rdData     = rdataQ;

  // R9: address, direction and write data stay put while selected
  a_r9_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> ($stable(busAddr) && $stable(busRw) && $stable(busDataOut)));

  // R10: chip select stays high at least two clocks between accesses
  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCsN) |=> busCsN);

  // R8: read data only moves on an edge that ends an access
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busCsN && $past(busCsN)) |-> $stable(rdData));

endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int WAIT_RST = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgAckEn,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              reqValid,
  input  logic              reqSdram,
  input  logic              taFall,
  output logic              reqReady,
  output btcStrobe_t        strobe,
  output logic              done,
  output logic              timeout
);

  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(WAIT_RST);

  btcState_e         state;
  logic              cfgAckEnQ;
  logic [WAIT_W-1:0] cfgWaitQ;
  logic [WAIT_W-1:0] waitCnt;
  logic              useAck;
  logic              doneQ;
  logic              timeoutQ;
  logic              inAccess;
  logic              ackHit;
  logic              cntOut;
  logic              termNow;

  // configuration, defaults: acknowledge off, full wait count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAckEnQ <= 1'b0;
      cfgWaitQ  <= WAIT_INIT;
    end else if (cfgLoad) begin
      cfgAckEnQ <= cfgAckEn;
      cfgWaitQ  <= cfgWait;
    end
  end

  always_comb begin
    inAccess = (state == ST_ACCESS);
    ackHit   = inAccess && useAck && taFall;
    cntOut   = inAccess && (waitCnt == '0);
    termNow  = ackHit || cntOut;
    reqReady = (state == ST_IDLE);
    strobe.latchReq = reqReady && reqValid;
    strobe.capRead  = termNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      useAck  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_ACCESS;
            waitCnt <= cfgWaitQ;
            useAck  <= cfgAckEnQ & ~reqSdram;
          end
        end
        ST_ACCESS: begin
          if (termNow) state   <= ST_RECOVER;
          else         waitCnt <= waitCnt - 1'b1;
        end
        ST_RECOVER: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // completion pulse; timeout only when the count beat an expected acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      doneQ    <= termNow;
      timeoutQ <= cntOut && !ackHit && useAck;
    end
  end

  assign done    = doneQ;
  assign timeout = timeoutQ;

  // R10: one clock of done per access
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: idle again right after completion
  a_r10_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

  // R7: timeout is only reported together with completion
  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> done);

  // R6: without acknowledge use, an access runs while the count is non-zero
  a_r6_count_rules: assert property (@(posedge clk) disable iff (!rstN)
    (inAccess && !useAck && waitCnt != '0) |=> (state == ST_ACCESS));

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 4,
  parameter int WAIT_RST    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              cfgAckEn,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:1]   reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqSdram,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timeout,
  output logic [ADDR_W:1]   busAddr,
  output logic              busRw,
  output logic              busCsN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busTaN
);

  btcStrobe_t strobe;
  logic       taFall;

  btc_ctrl #(
    .WAIT_W   (WAIT_W),
    .WAIT_RST (WAIT_RST)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .cfgAckEn (cfgAckEn),
    .cfgWait  (cfgWait),
    .reqValid (reqValid),
    .reqSdram (reqSdram),
    .taFall   (taFall),
    .reqReady (reqReady),
    .strobe   (strobe),
    .done     (done),
    .timeout  (timeout)
  );

  btc_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .busTaN     (busTaN),
    .busAddr    (busAddr),
    .busRw      (busRw),
    .busCsN     (busCsN),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .rdData     (rdData),
    .taFall     (taFall)
  );

endmodule

// File: tb/bus_term_ctrl_test.sv
module bus_term_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic        cfgAckEn = 1'b0;
  logic [3:0]  cfgWait = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [24:1] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        reqSdram = 1'b0;
  logic [15:0] rdData;
  logic        done;
  logic        timeout;
  logic [24:1] busAddr;
  logic        busRw;
  logic        busCsN;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;
  logic        busTaN = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  int curW    = 15;
  bit curEn   = 1'b0;

  always #5 clk = ~clk;

  bus_term_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgAckEn(cfgAckEn), .cfgWait(cfgWait),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqSdram(reqSdram), .rdData(rdData), .done(done),
    .timeout(timeout), .busAddr(busAddr), .busRw(busRw), .busCsN(busCsN),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn), .busTaN(busTaN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // edge (counted from acceptance) after which done must be seen
  function automatic int expDoneAt(input int w, input bit en, input bit sd, input int ackAt);
    if (en && !sd && ackAt >= 0 && ackAt + 3 <= w + 1) return ackAt + 3;
    return w + 1;
  endfunction

  function automatic bit expTimeout(input int w, input bit en, input bit sd, input int ackAt);
    return en && !sd && !(ackAt >= 0 && ackAt + 3 <= w + 1);
  endfunction

  task automatic loadCfg(input bit en, input int w);
    @(negedge clk);
    cfgLoad = 1'b1; cfgAckEn = en; cfgWait = 4'(w);
    @(negedge clk);
    cfgLoad = 1'b0;
    curEn = en; curW = w;
  endtask

  // ackAt: edge after which busTaN is lowered (-1 none); raiseAt: edge after which it is raised
  task automatic runAccess(input logic [24:1] a, input bit wr, input logic [15:0] wd,
                           input bit sd, input int ackAt, input int raiseAt,
                           input bit keepLow, input string forceTag);
    int exp;
    bit expTo;
    bit seen;
    bit stableOk;
    string tag;
    logic [15:0] rdv;
    exp   = expDoneAt(curW, curEn, sd, ackAt);
    expTo = expTimeout(curW, curEn, sd, ackAt);
    if (forceTag != "")           tag = forceTag;
    else if (sd)                  tag = "R6";
    else if (!curEn)              tag = (ackAt >= 0) ? "R5" : "R2";
    else if (expTo)               tag = "R7";
    else                          tag = "R3";
    while (!reqReady) @(negedge clk);
    rdv = 16'($urandom);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd; reqSdram = sd;
    busDataIn = rdv;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(busCsN == 1'b0, "R2", "chip select after accept", 32'(busCsN), 32'd0);
    check(busAddr == a, "R9", "address", 32'(busAddr), 32'(a));
    check(busRw == !wr, "R9", "read/write level", 32'(busRw), 32'(!wr));
    check(busDataOe == wr, "R9", "data drive enable", 32'(busDataOe), 32'(wr));
    if (wr) check(busDataOut == wd, "R9", "write data", 32'(busDataOut), 32'(wd));
    if (ackAt == 0) busTaN = 1'b0;
    seen = 1'b0;
    stableOk = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == exp) begin
        check(done == 1'b1, tag, "done at expected edge", 32'(done), 32'd1);
        check(timeout == expTo, "R7", "timeout flag", 32'(timeout), 32'(expTo));
        check(busCsN == 1'b1, "R10", "chip select high with done", 32'(busCsN), 32'd1);
        if (!wr) check(rdData == rdv, "R8", "read data", 32'(rdData), 32'(rdv));
        seen = 1'b1;
        break;
      end
      if (done) begin
        check(1'b0, tag, "early done edge", 32'(k), 32'(exp));
        seen = 1'b1;
        break;
      end
      if (busCsN || busAddr != a || busRw != !wr) stableOk = 1'b0;
      if (k == raiseAt) busTaN = 1'b1;
      if (k == ackAt) busTaN = 1'b0;
    end
    if (!seen) check(1'b0, tag, "done never seen", 32'd0, 32'(exp));
    check(stableOk, "R9", "bus held during access", 32'(stableOk), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single clock", 32'(done), 32'd0);
    check(reqReady == 1'b1, "R10", "ready after done", 32'(reqReady), 32'd1);
    if (!keepLow) busTaN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busCsN == 1'b1, "R1", "reset chip select", 32'(busCsN), 32'd1);
    check(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
    check(timeout == 1'b0, "R1", "reset timeout", 32'(timeout), 32'd0);
    check(busDataOe == 1'b0, "R1", "reset drive enable", 32'(busDataOe), 32'd0);
    check(reqReady == 1'b1, "R1", "reset ready", 32'(reqReady), 32'd1);
    // R1: default 15 waits, acknowledge ignored out of reset
    runAccess(24'h00_1234, 1'b0, 16'h0, 1'b0, 0, -1, 1'b0, "R1");
    runAccess(24'h12_0001, 1'b1, 16'hBEEF, 1'b0, -1, -1, 1'b0, "R1");

    // R11: new settings take effect; R3 acknowledge termination
    loadCfg(1'b1, 10);
    runAccess(24'h00_00A0, 1'b0, 16'h0, 1'b0, 1, -1, 1'b0, "");
    // R6: SDRAM ignores acknowledge
    runAccess(24'h00_00A2, 1'b0, 16'h0, 1'b1, 1, -1, 1'b0, "");
    // R7: enabled, no acknowledge
    runAccess(24'h00_00A4, 1'b1, 16'h5A5A, 1'b0, -1, -1, 1'b0, "");
    // R4: acknowledge ends this access and stays low into the next
    runAccess(24'h00_00B0, 1'b0, 16'h0, 1'b0, 2, -1, 1'b1, "R3");
    runAccess(24'h00_00B2, 1'b0, 16'h0, 1'b0, -1, -1, 1'b1, "R4");
    // R4: high then low again re-arms recognition, ends on edge 6
    runAccess(24'h00_00B4, 1'b1, 16'h1357, 1'b0, 3, 1, 1'b0, "R4");

    // R3/R7 tie: acknowledge and count on the same edge
    loadCfg(1'b1, 5);
    runAccess(24'h00_0C00, 1'b0, 16'h0, 1'b0, 3, -1, 1'b0, "R3");
    runAccess(24'h00_0C02, 1'b0, 16'h0, 1'b0, 4, -1, 1'b0, "R7");
    // zero wait count
    loadCfg(1'b1, 0);
    runAccess(24'h00_0D00, 1'b0, 16'h0, 1'b0, 0, -1, 1'b0, "R7");
    loadCfg(1'b0, 0);
    runAccess(24'h00_0D02, 1'b1, 16'hA0A0, 1'b0, -1, -1, 1'b0, "R2");
    // R5: disabled with an early acknowledge
    loadCfg(1'b0, 8);
    runAccess(24'h00_0E00, 1'b0, 16'h0, 1'b0, 0, -1, 1'b0, "R5");

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      int ack;
      if (i % 5 == 0) loadCfg(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) ack = -1;
      else ack = int'($urandom_range(0, curW + 3));
      runAccess(24'($urandom), 1'($urandom_range(0, 1)), 16'($urandom),
                1'($urandom_range(0, 4) == 0), ack, -1, 1'b0, "");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule